// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block multiplies two normalized floating-point significands over several clock cycles. It uses right-shifting shift-and-add. An accumulator, one bit wider than the significand, is shifted right one place per step. The multiplicand is added whenever the multiplier bit under the scan pointer is set. Every bit that falls off the bottom of the accumulator is ORed into a sticky flag, so a later rounding stage knows whether anything non-zero was lost. The multiplier is scanned word by word from the least significant end. A word of all-zero bits is consumed in a single cycle as one whole-word move, instead of one cycle per bit.

Operands use a fixed-point significand of `NWORDS*WORD_W` bits. The implicit one sits at bit `ONE_POS = NWORDS*WORD_W-3`, and the two bits above it are zero. The multiplier's lowest `GR_BITS` bits (guard and round) must be zero, so the scan begins at bit `GR_BITS`. It ends once bit `ONE_POS` has been processed. A final cycle normalizes the product, which can lie anywhere in [1, 4), with at most one right shift. The same cycle adds the exponents and combines the signs. A caller pulses `start` while the unit is idle and waits for the one-cycle `done`. Rounding, special values and subnormals belong to neighbouring logic.

Top module: `mant_shadd_mul`

## Requirements
- R1: When `done` is high, `mant_o` equals floor(X*Y / 2^ONE_POS). If that value is 2^(ONE_POS+1) or more, `mant_o` is that value shifted right by one.
- R2: When `done` is high, `sticky_o` is 1 exactly when some bit discarded from the exact product X*Y is non-zero. The discarded bits are the low ONE_POS bits, plus the bit removed by the normalizing shift.
- R3: When `done` is high, `exp_o` equals `exp_a + exp_b`, plus 1 when the normalizing shift was taken, modulo 2^EXP_W.
- R4: When `done` is high, `sign_o` equals `sign_a` XOR `sign_b`.
- R5: Busy time is one cycle for each all-zero multiplier word and one cycle per scanned bit for each other word, plus one normalize cycle. Word 0 is scanned from bit GR_BITS, and the last word up to bit ONE_POS.
- R6: `done` is high for exactly one cycle per operation, and `busy` is low whenever `done` is high.
- R7: A `start` pulse that arrives while `busy` is high is ignored, and the running operation finishes with its original operands.
- R8: After reset, `busy`, `done`, `mant_o`, `exp_o`, `sign_o` and `sticky_o` are all 0.
- R9: Every result is normalized: bit ONE_POS of `mant_o` is 1 and the bits above it are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while idle) |
| mant_a | input | NWORDS*WORD_W | Multiplicand significand, implicit one at bit ONE_POS |
| mant_b | input | NWORDS*WORD_W | Multiplier significand, low GR_BITS bits zero |
| exp_a | input | EXP_W | Multiplicand exponent |
| exp_b | input | EXP_W | Multiplier exponent |
| sign_a | input | 1 | Multiplicand sign |
| sign_b | input | 1 | Multiplier sign |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid strobe |
| mant_o | output | NWORDS*WORD_W | Normalized product significand |
| exp_o | output | EXP_W | Product exponent |
| sign_o | output | 1 | Product sign |
| sticky_o | output | 1 | OR of all discarded product bits |

## Verification
The bench builds the unit with `WORD_W=4`, `NWORDS=3` and `EXP_W=8`. This gives a 12-bit significand with the implicit one at bit 9. Here every one of the 128 legal multipliers can be swept against 64 spread multiplicands, with the full product computed as a plain integer. At this size zero words appear often in both the lowest and the middle word, and products at or above 2 are frequent. Both the word-skip timing and the normalizing shift are therefore hit thousands of times, together with exponent wrap-around at 8 bits.

// File: rtl/mant_mul_pkg.sv
package mant_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NORM = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_zero_words.sv
module mul_zero_words #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  localparam int MANT_W = WORD_W * NWORDS
) (
  input  logic [MANT_W-1:0] mult,
  output logic [NWORDS-1:0] zero
);
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign zero[w] = (mult[w*WORD_W +: WORD_W] == '0);
  end
endmodule

// File: rtl/mul_step.sv
module mul_step #(
  parameter int WORD_W = 32,
  parameter int MANT_W = 128
) (
  input  logic [MANT_W:0]   acc,
  input  logic [MANT_W-1:0] mcand,
  input  logic              bit_set,
  input  logic              skip_word,
  output logic [MANT_W:0]   acc_nxt,
  output logic              lost
);
  logic [MANT_W:0] shifted;

  always_comb begin
    if (skip_word) begin
      shifted = acc >> WORD_W;
      lost    = |acc[WORD_W-1:0];
      acc_nxt = shifted;
    end else begin
      shifted = acc >> 1;
      lost    = acc[0];
      acc_nxt = bit_set ? shifted + {1'b0, mcand} : shifted;
    end
  end
endmodule

// File: rtl/mul_norm.sv
module mul_norm #(
  parameter int MANT_W  = 128,
  parameter int ONE_POS = 125,
  parameter int EXP_W   = 16
) (
  input  logic [MANT_W:0]   acc,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [MANT_W-1:0] mant,
  output logic [EXP_W-1:0]  exp_out,
  output logic              lost
);
  logic wide;
  assign wide = acc[ONE_POS+1];

  always_comb begin
    if (wide) begin
      mant    = acc[MANT_W:1];
      lost    = acc[0];
      exp_out = exp_in + EXP_W'(1);
    end else begin
      mant    = acc[MANT_W-1:0];
      lost    = 1'b0;
      exp_out = exp_in;
    end
  end
endmodule

// File: rtl/mant_shadd_mul.sv
module mant_shadd_mul
  import mant_mul_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int NWORDS  = 4,
  parameter int GR_BITS = 2,
  parameter int EXP_W   = 16,
  localparam int MANT_W  = WORD_W * NWORDS,
  localparam int ONE_POS = MANT_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MANT_W-1:0] mant_a,
  input  logic [MANT_W-1:0] mant_b,
  input  logic [EXP_W-1:0]  exp_a,
  input  logic [EXP_W-1:0]  exp_b,
  input  logic              sign_a,
  input  logic              sign_b,
  output logic              busy,
  output logic              done,
  output logic [MANT_W-1:0] mant_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              sign_o,
  output logic              sticky_o
);
  localparam int PTR_W  = $clog2(MANT_W);
  localparam int WB     = $clog2(WORD_W);
  localparam int WIDX_W = $clog2(NWORDS);

  mul_state_e        st_q;
  logic [MANT_W-1:0] x_q, y_q;
  logic [MANT_W:0]   acc_q, acc_nxt;
  logic              stk_q, step_lost, norm_lost;
  logic [PTR_W-1:0]  ptr_q, ptr_word_base;
  logic [EXP_W-1:0]  exp_q, norm_exp;
  logic              sgn_q;
  logic [NWORDS-1:0] zero_vec;
  logic [WIDX_W-1:0] word_idx;
  logic              at_word_start, skip, last_bit;
  logic [MANT_W-1:0] norm_mant;

  mul_zero_words #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_zero (
    .mult (y_q),
    .zero (zero_vec)
  );

  assign word_idx      = WIDX_W'(ptr_q >> WB);
  assign at_word_start = (ptr_q[WB-1:0] == '0) || (ptr_q == PTR_W'(GR_BITS));
  assign skip          = at_word_start && zero_vec[word_idx];
  assign last_bit      = !skip && (ptr_q == PTR_W'(ONE_POS));
  assign ptr_word_base = PTR_W'(((ptr_q >> WB) + PTR_W'(1)) << WB);

  mul_step #(.WORD_W(WORD_W), .MANT_W(MANT_W)) u_step (
    .acc       (acc_q),
    .mcand     (x_q),
    .bit_set   (y_q[ptr_q]),
    .skip_word (skip),
    .acc_nxt   (acc_nxt),
    .lost      (step_lost)
  );

  mul_norm #(.MANT_W(MANT_W), .ONE_POS(ONE_POS), .EXP_W(EXP_W)) u_norm (
    .acc     (acc_q),
    .exp_in  (exp_q),
    .mant    (norm_mant),
    .exp_out (norm_exp),
    .lost    (norm_lost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      x_q      <= '0;
      y_q      <= '0;
      acc_q    <= '0;
      stk_q    <= 1'b0;
      ptr_q    <= '0;
      exp_q    <= '0;
      sgn_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mant_o   <= '0;
      exp_o    <= '0;
      sign_o   <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            x_q   <= mant_a;
            y_q   <= mant_b;
            acc_q <= '0;
            stk_q <= 1'b0;
            ptr_q <= PTR_W'(GR_BITS);
            exp_q <= exp_a + exp_b;
            sgn_q <= sign_a ^ sign_b;
            busy  <= 1'b1;
            st_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc_q <= acc_nxt;
          stk_q <= stk_q | step_lost;
          ptr_q <= skip ? ptr_word_base : ptr_q + PTR_W'(1);
          if (last_bit) st_q <= ST_NORM;
        end
        ST_NORM: begin
          mant_o   <= norm_mant;
          exp_o    <= norm_exp;
          sign_o   <= sgn_q;
          sticky_o <= stk_q | norm_lost;
          done     <= 1'b1;
          busy     <= 1'b0;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R9
  norm_out_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (mant_o[ONE_POS] && (mant_o >> (ONE_POS + 1)) == '0));
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(x_q) && $stable(y_q) && $stable(sgn_q)));
  // R7
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |-> (ptr_q <= PTR_W'(ONE_POS) && ptr_q >= PTR_W'(GR_BITS)));
endmodule

// File: tb/mant_shadd_mul_bench.sv
module mant_shadd_mul_bench;
  localparam int WORD_W  = 4;
  localparam int NWORDS  = 3;
  localparam int GR_BITS = 2;
  localparam int EXP_W   = 8;
  localparam int MANT_W  = WORD_W * NWORDS;
  localparam int ONE_POS = MANT_W - 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [MANT_W-1:0] mant_a = '0, mant_b = '0;
  logic [EXP_W-1:0]  exp_a = '0, exp_b = '0;
  logic              sign_a = 1'b0, sign_b = 1'b0;
  logic              busy, done, sign_o, sticky_o;
  logic [MANT_W-1:0] mant_o;
  logic [EXP_W-1:0]  exp_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  mant_shadd_mul #(.WORD_W(WORD_W), .NWORDS(NWORDS), .GR_BITS(GR_BITS), .EXP_W(EXP_W))
  u_mant_shadd_mul (
    .clk(clk), .rst(rst), .start(start),
    .mant_a(mant_a), .mant_b(mant_b), .exp_a(exp_a), .exp_b(exp_b),
    .sign_a(sign_a), .sign_b(sign_b),
    .busy(busy), .done(done), .mant_o(mant_o), .exp_o(exp_o),
    .sign_o(sign_o), .sticky_o(sticky_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 180000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One operation; optional start pulse with other operands while busy (R7).
  task automatic run_op(input int x, input int y, input int ea, input int eb,
                        input bit sa, input bit sb, input bit poke);
    longint full, a, m_exp;
    int e_exp, lat, exp_lat, w0, w1;
    bit st_exp;
    full  = longint'(x) * longint'(y);
    a     = full >> ONE_POS;
    st_exp = (full % (longint'(1) << ONE_POS)) != 0;
    e_exp = (ea + eb) % 256;
    if (a >= (longint'(1) << (ONE_POS + 1))) begin
      st_exp = st_exp | a[0];
      a = a >> 1;
      e_exp = (e_exp + 1) % 256;
    end
    m_exp = a;
    w0 = (y >> 2) & 3;
    w1 = (y >> 4) & 15;
    exp_lat = ((w0 == 0) ? 1 : 2) + ((w1 == 0) ? 1 : 4) + 2 + 1;

    @(negedge clk);
    mant_a = MANT_W'(x); mant_b = MANT_W'(y);
    exp_a = EXP_W'(ea); exp_b = EXP_W'(eb); sign_a = sa; sign_b = sb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    if (poke) begin
      mant_a = MANT_W'(1023); mant_b = MANT_W'(1020);
      exp_a = EXP_W'(200); sign_a = ~sa;
      start = 1'b1;
    end
    for (int i = 0; i < 100; i++) begin
      if (done) break;
      if (busy) lat++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1 && busy == 1'b0, "R6 done with busy low", {done, busy}, 2);
    chk(mant_o == MANT_W'(m_exp), poke ? "R7 mantissa after ignored start" : "R1 mantissa",
        mant_o, m_exp);
    chk(sticky_o == st_exp, "R2 sticky", sticky_o, st_exp);
    chk(exp_o == EXP_W'(e_exp), "R3 exponent", exp_o, e_exp);
    chk(sign_o == (sa ^ sb), "R4 sign", sign_o, sa ^ sb);
    chk(lat == exp_lat, "R5 busy cycles", lat, exp_lat);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mant_o == 0 && exp_o == 0 && sign_o == 0 && sticky_o == 0,
        "R8 reset state", {busy, done, sign_o, sticky_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R8 idle after reset", {busy, done}, 0);

    // Directed corners: exact 1.0 * 1.0, largest operands (R1 R2 R9 normalize)
    run_op(512, 512, 10, 20, 1'b0, 1'b0, 1'b0);
    run_op(1023, 1020, 255, 255, 1'b1, 1'b0, 1'b0);
    run_op(512, 516, 0, 0, 1'b1, 1'b1, 1'b0);
    // R7: start while busy is ignored
    run_op(600, 800, 3, 4, 1'b0, 1'b1, 1'b1);
    run_op(513, 512, 128, 128, 1'b1, 1'b1, 1'b1);

    // Sweep: all 128 legal multipliers against 64 multiplicands
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < 128; j++) begin
        run_op(512 | ((k * 73 + 5) % 512), 512 | (j << GR_BITS),
               (k * 11) % 256, (j * 7) % 256, k[0], j[1], 1'b0);
      end
    end
    summary();
  end
endmodule